// File: doc/BRIEF.md
# Two-Level Debug Trigger Controller

This block holds the write-only 32-bit trigger definition of an on-chip debug unit and turns it into trigger events. The word is split into two 16-bit halves, one per trigger level. Each level can require a data match, an address match and a program-counter match. All enabled conditions of a level must hold in the same bus beat for that level to fire. Address and PC comparison happen outside the block; only their hit flags arrive here. The data comparison is done inside. It compares the masked bus value with a compare value, and it only counts a comparison when the lane-enable bit for the size and byte position of the access is set.

When the trigger completes, the block raises a one-cycle display pulse. Depending on the 2-bit response code it also raises a one-cycle processor-halt request or debug-interrupt request. A 4-bit status field records which levels have fired and how the trigger completed. Any write to the definition clears that status. The word can be written through two paths: a supervisor debug-register write to index 7, or a debug-port write.

The bus side is a snooped stream. `bus_valid` marks a beat, and every marked beat is evaluated. There is no ready signal and no back-pressure, because the block never stalls the bus it observes. The write ports, the hit flags and all outputs are plain level or pulse signals.

Top module: `dbg_trig_ctrl`

## Requirements
- R1: After reset the definition word is all zeros, every output is 0, and no bus beat can fire either level or complete a trigger.
- R2: A supervisor write loads the word only when `sup_wr_idx` equals 7; any other index leaves the word unchanged. A debug-port write always loads it. If both paths write in the same cycle, the debug-port value is taken.
- R3: Any accepted write sets `trig_sts` to 0 in the following cycle and produces no pulse in that cycle. Bus beats presented in a write cycle are not evaluated.
- R4: Per level, the seven data-enable bits (level 2 at bits 28..22, level 1 at bits 12..6) select lanes from most to least significant as follows: the full longword (`bus_be`=1111), the low half-word (0011), the high half-word (1100), byte [7:0] (0001), byte [15:8] (0010), byte [23:16] (0100), byte [31:24] (1000). A data condition can only be true when the bit for the beat's `bus_be` pattern is set. Any other `bus_be` value never gives a data hit.
- R5: The data condition compares `(bus_data ^ cmp_data) & cmp_mask` on the selected lane's bytes and is true when that is zero. The data-invert bit (bit 21 for level 2, bit 5 for level 1) flips the result, but only for a beat whose lane is enabled.
- R6: Each level has an enable bit (bit 29 for level 2, bit 13 for level 1). A level whose enable bit is 0, or whose data-enable bits, address-enable bits (bits 20..18 / 4..2) and PC-enable bit (bit 17 / 1) are all 0, never fires.
- R7: A level fires on a valid beat when every enabled condition holds together. The address condition is that level's `addr_hit` bit. The PC condition is that level's `pc_hit` bit XOR the PC-invert bit (bit 16 / bit 0). Bit 0 of the hit vectors belongs to level 1.
- R8: Response code bits 31..30 set the outputs when a trigger completes. 00 gives `trig_pulse` only, 01 adds `halt_req`, 10 adds `dbg_irq`, and the reserved code 11 behaves like 00. Each pulse lasts exactly one cycle.
- R9: `trig_sts` bit 0 is set when level 1 has fired, bit 1 when level 2 has fired, bit 2 when the trigger has completed, and bit 3 when the completion came from level 2. All bits are sticky until the next write, and a trigger completes at most once between writes.
- R10: Level 1 completes the trigger on its own only when bit 14 is set. Level 2 completes it directly when bit 15 is 0. When bit 15 is 1, level 2 completes it only if level 1 fired in an earlier beat since the last write.
- R11: Status and pulses appear in the cycle right after the clock edge that samples the beat or the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_wr_en | input | 1 | Supervisor debug-register write strobe |
| sup_wr_idx | input | 5 | Debug-register index of the supervisor write |
| sup_wr_data | input | 32 | Supervisor write data |
| port_wr_en | input | 1 | Debug-port write strobe |
| port_wr_data | input | 32 | Debug-port write data |
| bus_valid | input | 1 | Bus beat present this cycle |
| bus_data | input | 32 | Bus data value |
| bus_be | input | 4 | Byte enables of the beat (size and position) |
| cmp_data | input | 32 | Data breakpoint compare value |
| cmp_mask | input | 32 | Data breakpoint mask, 1 = bit compared |
| addr_hit | input | 2 | Address comparator hits, bit 0 level 1 |
| pc_hit | input | 2 | PC comparator hits, bit 0 level 1 |
| trig_pulse | output | 1 | One-cycle trigger completion display pulse |
| halt_req | output | 1 | One-cycle processor halt request |
| dbg_irq | output | 1 | One-cycle debug interrupt request |
| trig_sts | output | 4 | Trigger status field |

## Verification
Writes and bus beats share one timing rule. The clock edge that samples a beat or a write updates the word, the status and the pulses, so every result is due one cycle after the stimulus. The bench drives each stimulus on a falling edge and checks all four outputs on the next falling edge, after exactly one rising edge. At that point it compares them with a bench model that has been advanced by the same stimulus. A one-cycle pulse is therefore seen in the only cycle it exists, and the following beat then checks that it has dropped again.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam int LVL_W   = 16;
  localparam int N_LVL   = 2;
  localparam int ED_W    = 7;
  localparam int EA_W    = 3;
  localparam int STS_W   = 4;

  // One trigger level, most significant field first
  typedef struct packed {
    logic [1:0]      ctl;   // level 2: response code; level 1: {seq, direct}
    logic            ebl;
    logic [ED_W-1:0] ed;
    logic            di;
    logic [EA_W-1:0] ea;
    logic            epc;
    logic            pci;
  } lvl_cfg_t;

  typedef enum logic [1:0] {
    RESP_SHOW = 2'b00,
    RESP_HALT = 2'b01,
    RESP_IRQ  = 2'b10,
    RESP_RSVD = 2'b11
  } resp_e;
endpackage

// File: rtl/dbg_trig_lane_match.sv
module dbg_trig_lane_match #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   bus_data,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   cmp_data,
  input  logic [DATA_W-1:0]   cmp_mask,
  input  logic [DATA_W/8+DATA_W/16:0] ed,
  input  logic                di,
  output logic                hit
);
  localparam int BYTES  = DATA_W / 8;
  localparam int HALVES = BYTES / 2;
  localparam int HB     = BYTES / 2;
  localparam int LONG_I = BYTES + HALVES;

  logic [DATA_W-1:0] diff;
  logic [BYTES-1:0]  eq_byte;
  logic [HALVES-1:0] eq_half;
  logic [BYTES-1:0]  hit_byte;
  logic [HALVES-1:0] hit_half;
  logic              hit_long;

  assign diff = (bus_data ^ cmp_data) & cmp_mask;

  // R4: byte lanes, enable index counts down from byte 0
  for (genvar j = 0; j < BYTES; j++) begin : g_byte
    logic [BYTES-1:0] pat;
    assign pat         = BYTES'(1) << j;
    assign eq_byte[j]  = ~|diff[8*j +: 8];
    assign hit_byte[j] = (bus_be == pat) && ed[BYTES-1-j] && (eq_byte[j] ^ di);
  end

  // R4: half-word lanes
  for (genvar k = 0; k < HALVES; k++) begin : g_half
    logic [BYTES-1:0] pat;
    assign pat         = {{(BYTES-HB){1'b0}}, {HB{1'b1}}} << (HB*k);
    assign eq_half[k]  = &eq_byte[HB*k +: HB];
    assign hit_half[k] = (bus_be == pat) && ed[LONG_I-1-k] && (eq_half[k] ^ di);
  end

  // R5: longword lane, invert only applies when a lane is selected
  assign hit_long = (&bus_be) && ed[LONG_I] && ((&eq_byte) ^ di);
  assign hit      = hit_long | (|hit_half) | (|hit_byte);
endmodule

// File: rtl/dbg_trig_level.sv
module dbg_trig_level
  import dbg_trig_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  lvl_cfg_t            cfg,
  input  logic                bus_valid,
  input  logic [DATA_W-1:0]   bus_data,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   cmp_data,
  input  logic [DATA_W-1:0]   cmp_mask,
  input  logic                addr_hit,
  input  logic                pc_hit,
  output logic                fire
);
  logic data_on, addr_on, pc_on, armed, d_hit;

  dbg_trig_lane_match #(.DATA_W(DATA_W)) u_lane (
    .bus_data (bus_data),
    .bus_be   (bus_be),
    .cmp_data (cmp_data),
    .cmp_mask (cmp_mask),
    .ed       (cfg.ed),
    .di       (cfg.di),
    .hit      (d_hit)
  );

  // R6: armed only with the level enable and at least one condition
  assign data_on = |cfg.ed;
  assign addr_on = |cfg.ea;
  assign pc_on   = cfg.epc;
  assign armed   = cfg.ebl && (data_on || addr_on || pc_on);

  // R7: enabled conditions are ANDed
  assign fire = bus_valid && armed
             && (!data_on || d_hit)
             && (!addr_on || addr_hit)
             && (!pc_on   || (pc_hit ^ cfg.pci));
endmodule

// File: rtl/dbg_trig_resp.sv
module dbg_trig_resp
  import dbg_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [N_LVL-1:0] fire,
  input  logic             seq_mode,
  input  logic             l1_direct,
  input  resp_e            code,
  output logic             trig_pulse,
  output logic             halt_req,
  output logic             dbg_irq,
  output logic [STS_W-1:0] sts
);
  logic [STS_W-1:0] sts_q;
  logic c1, c2, done;

  // R10: completion paths
  assign c1   = fire[0] && l1_direct;
  assign c2   = fire[1] && (!seq_mode || sts_q[0]);
  assign done = (c1 || c2) && !sts_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q      <= '0;
      trig_pulse <= 1'b0;
      halt_req   <= 1'b0;
      dbg_irq    <= 1'b0;
    end else if (clr) begin
      sts_q      <= '0;
      trig_pulse <= 1'b0;
      halt_req   <= 1'b0;
      dbg_irq    <= 1'b0;
    end else begin
      sts_q[0] <= sts_q[0] | fire[0];
      sts_q[1] <= sts_q[1] | fire[1];
      if (done) begin
        sts_q[2] <= 1'b1;
        sts_q[3] <= c2;
      end
      trig_pulse <= done;
      halt_req   <= done && (code == RESP_HALT);  // R8
      dbg_irq    <= done && (code == RESP_IRQ);   // R8
    end
  end

  assign sts = sts_q;

  AST_HALT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> !halt_req); // R8
  AST_IRQ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_irq |=> !dbg_irq); // R8
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_req && dbg_irq)); // R8
  AST_REQ_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req || dbg_irq) |-> trig_pulse); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && sts_q[2]) |=> sts_q[2]); // R9
  AST_PULSE_MARKS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> sts_q[2]); // R9
endmodule

// File: rtl/dbg_trig_ctrl.sv
module dbg_trig_ctrl
  import dbg_trig_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 5,
  parameter int REG_IDX = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sup_wr_en,
  input  logic [IDX_W-1:0]    sup_wr_idx,
  input  logic [31:0]         sup_wr_data,
  input  logic                port_wr_en,
  input  logic [31:0]         port_wr_data,
  input  logic                bus_valid,
  input  logic [DATA_W-1:0]   bus_data,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   cmp_data,
  input  logic [DATA_W-1:0]   cmp_mask,
  input  logic [1:0]          addr_hit,
  input  logic [1:0]          pc_hit,
  output logic                trig_pulse,
  output logic                halt_req,
  output logic                dbg_irq,
  output logic [3:0]          trig_sts
);
  localparam int WORD_W = LVL_W * N_LVL;

  logic [WORD_W-1:0] def_q, wr_val;
  logic              wr_any, sup_hit;
  lvl_cfg_t          cfg [N_LVL];
  logic [N_LVL-1:0]  fire;

  // R2: index decode and path priority
  assign sup_hit = sup_wr_en && (sup_wr_idx == IDX_W'(REG_IDX));
  always_comb begin
    wr_any = port_wr_en || sup_hit;
    wr_val = port_wr_en ? port_wr_data : sup_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      def_q <= '0;     // R1
    else if (wr_any) def_q <= wr_val;
  end

  for (genvar i = 0; i < N_LVL; i++) begin : g_lvl
    assign cfg[i] = lvl_cfg_t'(def_q[LVL_W*i +: LVL_W]);
    dbg_trig_level #(.DATA_W(DATA_W)) u_level (
      .cfg       (cfg[i]),
      .bus_valid (bus_valid && !wr_any),  // R3: write cycle wins
      .bus_data  (bus_data),
      .bus_be    (bus_be),
      .cmp_data  (cmp_data),
      .cmp_mask  (cmp_mask),
      .addr_hit  (addr_hit[i]),
      .pc_hit    (pc_hit[i]),
      .fire      (fire[i])
    );
  end

  dbg_trig_resp u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (wr_any),
    .fire       (fire),
    .seq_mode   (cfg[0].ctl[1]),
    .l1_direct  (cfg[0].ctl[0]),
    .code       (resp_e'(cfg[N_LVL-1].ctl)),
    .trig_pulse (trig_pulse),
    .halt_req   (halt_req),
    .dbg_irq    (dbg_irq),
    .sts        (trig_sts)
  );

  AST_WR_CLEARS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> (trig_sts == '0)); // R3
  AST_WR_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> !trig_pulse); // R3
  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !trig_pulse); // R11
  AST_ZERO_DEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (def_q == '0 && !wr_any) |=> (trig_sts == '0)); // R1
endmodule

// File: tb/dbg_trig_ctrl_test.sv
module dbg_trig_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sup_wr_en = 0, port_wr_en = 0, bus_valid = 0;
  logic [4:0]  sup_wr_idx = 0;
  logic [31:0] sup_wr_data = 0, port_wr_data = 0;
  logic [31:0] bus_data = 0, cmp_data = 0, cmp_mask = 0;
  logic [3:0]  bus_be = 0;
  logic [1:0]  addr_hit = 0, pc_hit = 0;
  logic        trig_pulse, halt_req, dbg_irq;
  logic [3:0]  trig_sts;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // bench model state
  logic [31:0] m_def = 0;
  logic [3:0]  m_sts = 0;
  logic        m_pulse = 0, m_halt = 0, m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_trig_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .sup_wr_en(sup_wr_en), .sup_wr_idx(sup_wr_idx), .sup_wr_data(sup_wr_data),
    .port_wr_en(port_wr_en), .port_wr_data(port_wr_data),
    .bus_valid(bus_valid), .bus_data(bus_data), .bus_be(bus_be),
    .cmp_data(cmp_data), .cmp_mask(cmp_mask),
    .addr_hit(addr_hit), .pc_hit(pc_hit),
    .trig_pulse(trig_pulse), .halt_req(halt_req), .dbg_irq(dbg_irq),
    .trig_sts(trig_sts)
  );

  // R4/R5 data condition from the requirement text
  function automatic bit data_cond(input logic [15:0] h, input logic [31:0] d,
                                   input logic [3:0] be, input logic [31:0] c,
                                   input logic [31:0] m);
    logic [6:0] ed = h[12:6];
    bit en;
    logic [31:0] lm;
    case (be)
      4'hF: begin en = ed[6]; lm = 32'hFFFF_FFFF; end
      4'h3: begin en = ed[5]; lm = 32'h0000_FFFF; end
      4'hC: begin en = ed[4]; lm = 32'hFFFF_0000; end
      4'h1: begin en = ed[3]; lm = 32'h0000_00FF; end
      4'h2: begin en = ed[2]; lm = 32'h0000_FF00; end
      4'h4: begin en = ed[1]; lm = 32'h00FF_0000; end
      4'h8: begin en = ed[0]; lm = 32'hFF00_0000; end
      default: begin en = 0; lm = 0; end
    endcase
    if (!en) return 0;
    return (((d ^ c) & m & lm) == 0) ^ h[5];
  endfunction

  // R6/R7 level firing
  function automatic bit lvl_fire(input logic [15:0] h, input bit ah, input bit ph);
    bit don = |h[12:6], aon = |h[4:2], pon = h[1];
    if (!h[13] || !(don || aon || pon)) return 0;
    if (don && !data_cond(h, bus_data, bus_be, cmp_data, cmp_mask)) return 0;
    if (aon && !ah) return 0;
    if (pon && !(ph ^ h[0])) return 0;
    return 1;
  endfunction

  task automatic model_step();
    bit wr = port_wr_en || (sup_wr_en && sup_wr_idx == 5'd7);
    if (wr) begin
      m_def = port_wr_en ? port_wr_data : sup_wr_data;
      m_sts = 0; m_pulse = 0; m_halt = 0; m_irq = 0;
    end else if (bus_valid) begin
      bit f1 = lvl_fire(m_def[15:0], addr_hit[0], pc_hit[0]);
      bit f2 = lvl_fire(m_def[31:16], addr_hit[1], pc_hit[1]);
      bit c1 = f1 && m_def[14];
      bit c2 = f2 && (!m_def[15] || m_sts[0]);
      bit dn = (c1 || c2) && !m_sts[2];
      m_sts[0] |= f1;
      m_sts[1] |= f2;
      if (dn) begin m_sts[2] = 1; m_sts[3] = c2; end
      m_pulse = dn;
      m_halt  = dn && m_def[31:30] == 2'b01;
      m_irq   = dn && m_def[31:30] == 2'b10;
    end else begin
      m_pulse = 0; m_halt = 0; m_irq = 0;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: model advances, outputs checked after one rising edge (R11)
  task automatic cycle(input string tag);
    model_step();
    @(negedge clk);
    chk({tag, " trig_pulse"}, 32'(trig_pulse), 32'(m_pulse));
    chk({tag, " halt_req"},   32'(halt_req),   32'(m_halt));
    chk({tag, " dbg_irq"},    32'(dbg_irq),    32'(m_irq));
    chk({tag, " trig_sts"},   32'(trig_sts),   32'(m_sts));
  endtask

  task automatic wr(input bit via_port, input logic [4:0] idx, input logic [31:0] v,
                    input string tag);
    bus_valid = 0;
    port_wr_en = via_port; port_wr_data = v;
    sup_wr_en = !via_port; sup_wr_idx = idx; sup_wr_data = v;
    cycle(tag);
    port_wr_en = 0; sup_wr_en = 0;
  endtask

  task automatic beat(input logic [31:0] d, input logic [3:0] be,
                      input logic [1:0] ah, input logic [1:0] ph, input string tag);
    bus_valid = 1; bus_data = d; bus_be = be; addr_hit = ah; pc_hit = ph;
    cycle(tag);
    bus_valid = 0;
  endtask

  function automatic logic [3:0] rand_be();
    logic [3:0] t [8] = '{4'hF, 4'h3, 4'hC, 4'h1, 4'h2, 4'h4, 4'h8, 4'h6};
    return t[$urandom_range(0, 7)];
  endfunction

  function automatic logic [15:0] rand_half();
    logic [15:0] h = 16'($urandom);
    if ($urandom_range(0, 3) == 0) h[13] = 0; else h[13] = 1;
    if ($urandom_range(0, 1) == 0) h[12:6] = 0;
    if ($urandom_range(0, 1) == 0) h[4:2] = 0;
    return h;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    cmp_mask = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 reset trig_sts", 32'(trig_sts), 0);
    chk("R1 reset pulses", 32'({trig_pulse, halt_req, dbg_irq}), 0);
    beat(32'h0, 4'hF, 2'b11, 2'b11, "R1 zero definition");

    // R2 wrong index ignored, right index loads
    wr(0, 5'd6, 32'h4000_6002, "R2 index 6");
    beat(32'h0, 4'hF, 2'b00, 2'b01, "R2 ignored write");
    chk("R2 no trigger after index 6", 32'(trig_pulse), 0);
    wr(0, 5'd7, 32'h4000_6002, "R2 index 7");
    beat(32'h0, 4'hF, 2'b00, 2'b01, "R8 halt");
    chk("R8 halt raised", 32'(halt_req), 1);
    chk("R9 status level1 direct", 32'(trig_sts), 32'h5);
    beat(32'h0, 4'hF, 2'b00, 2'b01, "R8 one cycle");
    chk("R8 halt dropped", 32'(halt_req), 0);

    // R3 write clears status
    wr(1, 5'd0, 32'h4000_6002, "R3 clear");
    chk("R3 status cleared", 32'(trig_sts), 0);

    // R2 both paths: port wins (irq code)
    port_wr_en = 1; port_wr_data = 32'h8000_6002;
    sup_wr_en = 1; sup_wr_idx = 5'd7; sup_wr_data = 32'h4000_6002;
    bus_valid = 0;
    cycle("R2 both paths");
    port_wr_en = 0; sup_wr_en = 0;
    beat(32'h0, 4'hF, 2'b00, 2'b01, "R2 port priority");
    chk("R2 port value used", 32'({halt_req, dbg_irq}), 32'b01);

    // R8 reserved code
    wr(1, 0, 32'hC000_6002, "R8 reserved");
    beat(32'h0, 4'hF, 2'b00, 2'b01, "R8 reserved fire");
    chk("R8 reserved display only", 32'({trig_pulse, halt_req, dbg_irq}), 32'b100);

    // R7 AND of address and PC
    wr(1, 0, 32'h0000_6006, "R7 cfg");
    beat(32'h0, 4'hF, 2'b00, 2'b01, "R7 pc only");
    chk("R7 pc without address", 32'(trig_pulse), 0);
    beat(32'h0, 4'hF, 2'b01, 2'b01, "R7 both");
    chk("R7 both conditions", 32'(trig_pulse), 1);

    // R10 sequence
    wr(1, 0, 32'hA002_A002, "R10 cfg");
    beat(32'h0, 4'hF, 2'b00, 2'b10, "R10 level2 first");
    chk("R10 level2 alone held", 32'(trig_sts), 32'h2);
    beat(32'h0, 4'hF, 2'b00, 2'b01, "R10 level1");
    chk("R10 level1 no completion", 32'(trig_sts), 32'h3);
    beat(32'h0, 4'hF, 2'b00, 2'b10, "R10 level2 after");
    chk("R10 sequence completes", 32'({dbg_irq, trig_sts}), 32'h1F);

    // R4/R5 lanes and invert
    cmp_data = 32'h0000_AB00;
    wr(1, 0, 32'h2100_0000, "R4 cfg");
    beat(32'h1234_AB78, 4'h1, 0, 0, "R4 wrong lane");
    chk("R4 disabled lane", 32'(trig_sts), 0);
    beat(32'h1234_AC78, 4'h2, 0, 0, "R5 mismatch");
    chk("R5 data mismatch", 32'(trig_sts), 0);
    beat(32'h1234_AB78, 4'h2, 0, 0, "R5 match");
    chk("R5 data match", 32'(trig_sts), 32'hE);
    wr(1, 0, 32'h2120_0000, "R5 invert cfg");
    beat(32'h1234_AC78, 4'h2, 0, 0, "R5 invert");
    chk("R5 inverted mismatch fires", 32'(trig_pulse), 1);
    wr(1, 0, 32'h2120_0000, "R5 invert cfg 2");
    beat(32'h1234_AC78, 4'h1, 0, 0, "R5 invert off-lane");
    chk("R5 invert needs lane", 32'(trig_pulse), 0);

    // R6 level disabled by its enable
    wr(1, 0, 32'h0102_0000, "R6 cfg");
    beat(32'h0, 4'hF, 2'b10, 2'b10, "R6 disabled");
    chk("R6 no fire without enable", 32'(trig_sts), 0);

    // random mix, R3 also exercised by writes with beats pending
    for (int r = 0; r < 400; r++) begin
      logic [31:0] v = {rand_half(), rand_half()};
      int path = $urandom_range(0, 3);
      cmp_data = $urandom; cmp_mask = ($urandom_range(0, 1) != 0) ? 32'hFFFF_FFFF : $urandom;
      if (path == 0) wr(0, 5'($urandom_range(0, 31)), v, "R2 random sup");
      else           wr(path != 1, 5'd7, v, "R2 random");
      for (int b = 0; b < 16; b++) begin
        logic [31:0] d = ($urandom_range(0, 1) != 0) ? cmp_data : $urandom;
        if ($urandom_range(0, 9) == 0) begin
          port_wr_en = 1; port_wr_data = v;
          bus_valid = 1; bus_data = d; bus_be = rand_be();
          cycle("R3 write with beat");
          port_wr_en = 0; bus_valid = 0;
        end else if ($urandom_range(0, 5) == 0) begin
          bus_valid = 0;
          cycle("R11 idle");
        end else begin
          beat(d, rand_be(), 2'($urandom), 2'($urandom), "R9 random");
        end
      end
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule